// File: doc/BRIEF.md
# Frequency-locked loop controller

This block steers an external digitally controlled oscillator towards a target frequency. It produces a coarse and a fine tuning word. It measures the oscillator by counting oscillator strobes over a window of a programmable number of reference strobes. It then compares that count with a multiplier that has an integer part and a 16-bit fraction, and moves the tuning words to cancel the difference.

Closed-loop tuning runs in two stages. The coarse word is corrected first, and then the fine word, each with its own step limit. When the fine word has settled, a tracking stage can dither the fine word's LSB. A phase accumulator fed by the fraction sets the duty cycle, which gives fractional ratios. In open-loop mode the controller only presents the loaded tuning words. In this mode it needs no reference. A configuration is captured when the enable goes high from idle.

Top module: `freq_lock_ctrl`

## Requirements
- R1: After reset the coarse and fine outputs are 0 and all three lock flags are 0.
- R2: With `closed_loop` = 0, enabling loads `init_coarse` and `init_fine` onto the outputs one cycle later. The outputs then stay constant whatever strobes arrive, and no lock flag sets.
- R3: In closed-loop mode a window closes on the `ref_div`-th reference strobe. Its count includes an oscillator strobe that arrives in the same cycle as that closing reference strobe. The window error is `mul_int` + dither bit − count, and the tuning words update in the cycle the window closes.
- R4: Each correction adds the error, clamped to ±`max_coarse` in the coarse stage or ±`max_fine` in the fine stage, to the active word. A limit input of 0 selects half of full scale, which is 32 for coarse and 128 for fine at the default widths.
- R5: A tuning word saturates at 0 and at its all-ones value and never wraps.
- R6: The coarse stage ends on a window whose error is 0, or whose sign is opposite to that of the previous window's error in the same stage. That window leaves the coarse word unchanged and sets `coarse_lock`, and the word stays frozen from then on.
- R7: The fine stage ends by the same rule. That window leaves the fine word unchanged and sets `fine_lock`. The fine stage begins with no previous error, so its first window cannot count as a reversal.
- R8: After fine lock with `dither_en` = 1, each window adds `mul_frac` to a 16-bit phase that starts at 0. A carry out sets a dither bit for the next window. That bit adds one to the `fine` output, saturating, and one to the expected count.
- R9: `accurate_lock` sets when `acc_windows` consecutive tracking windows have a zero error, with a setting of 0 taken as 1. It then stays set until the enable is cleared, even if later windows have an error.
- R10: With `dither_en` = 0, `accurate_lock` never sets and the `fine` output never carries a dither increment, whatever `mul_frac` holds.
- R11: One cycle after `en` falls, all lock flags are 0. Configuration inputs that change while enabled have no effect until the next enable from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run; a rising edge from idle captures configuration |
| closed_loop | input | 1 | 1 selects closed-loop tuning, 0 selects open loop |
| ref_tick | input | 1 | One-cycle reference strobe |
| dco_tick | input | 1 | One-cycle oscillator strobe |
| ref_div | input | DW | Reference strobes per window |
| mul_int | input | MW | Integer part of the multiplier |
| mul_frac | input | 16 | Fractional part of the multiplier |
| init_coarse | input | CW | Starting coarse word |
| init_fine | input | FW | Starting fine word |
| max_coarse | input | CW | Coarse step limit, 0 selects half scale |
| max_fine | input | FW | Fine step limit, 0 selects half scale |
| dither_en | input | 1 | Enable LSB dithering in the tracking stage |
| acc_windows | input | AW | Zero-error windows required for accurate lock |
| coarse | output | CW | Coarse tuning word |
| fine | output | FW | Fine tuning word including the dither bit |
| coarse_lock | output | 1 | Coarse word settled |
| fine_lock | output | 1 | Fine word settled |
| accurate_lock | output | 1 | Dither duty cycle settled |

## Verification
The collision that matters is an oscillator strobe arriving in the same cycle as the reference strobe that closes the window. That strobe must be counted into the closing window and must not leak into the next one. The bench provokes this by merging the last oscillator pulse of a fine-stage window into the final reference pulse. A count of 49 against a multiplier of 50 must then move the fine word by exactly one, to 104 rather than 105. A dropped or misplaced strobe shows up as the wrong word in that window and as a shifted lock point in the windows that follow.

// File: rtl/freq_lock_ctrl.sv
module freq_lock_ctrl #(
  parameter int CW   = 6,
  parameter int FW   = 8,
  parameter int MW   = 12,
  parameter int DW   = 8,
  parameter int CNTW = 16,
  parameter int AW   = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          closed_loop,
  input  logic          ref_tick,
  input  logic          dco_tick,
  input  logic [DW-1:0] ref_div,
  input  logic [MW-1:0] mul_int,
  input  logic [15:0]   mul_frac,
  input  logic [CW-1:0] init_coarse,
  input  logic [FW-1:0] init_fine,
  input  logic [CW-1:0] max_coarse,
  input  logic [FW-1:0] max_fine,
  input  logic          dither_en,
  input  logic [AW-1:0] acc_windows,
  output logic [CW-1:0] coarse,
  output logic [FW-1:0] fine,
  output logic          coarse_lock,
  output logic          fine_lock,
  output logic          accurate_lock
);
  localparam int EW = CNTW + 2;
  localparam logic [CW-1:0] C_HALF = {1'b1, {(CW-1){1'b0}}};
  localparam logic [FW-1:0] F_HALF = {1'b1, {(FW-1){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_OPEN, S_COARSE, S_FINE, S_TRACK} st_t;
  st_t st;

  logic [DW-1:0]   div_r, rcnt;
  logic [MW-1:0]   mul_r;
  logic [15:0]     frac_r, phase;
  logic [CW-1:0]   maxc_r, crs;
  logic [FW-1:0]   maxf_r, fin;
  logic [AW-1:0]   accn_r, zrun;
  logic [CNTW-1:0] dcnt;
  logic            dith_r, dbit, prev_ok, prev_neg;
  logic            lock_c, lock_f, lock_a;

  logic [DW-1:0]   div_eff;
  logic [AW-1:0]   acc_eff;
  logic [CNTW-1:0] cnt;
  logic            win_end, turn, looping;
  logic signed [EW-1:0] err, lim, step, csum, fsum;
  logic [CW-1:0]   crs_nx;
  logic [FW-1:0]   fin_nx;
  logic [16:0]     ph_sum;

  assign div_eff = (div_r == '0) ? DW'(1) : div_r;
  assign acc_eff = (accn_r == '0) ? AW'(1) : accn_r;
  assign looping = (st == S_COARSE) || (st == S_FINE) || (st == S_TRACK);
  assign win_end = looping && ref_tick && (rcnt == div_eff - DW'(1));
  assign cnt     = dcnt + CNTW'(dco_tick);
  assign err     = $signed(EW'(mul_r)) + $signed(EW'(dbit)) - $signed(EW'(cnt));
  assign lim     = (st == S_COARSE) ? $signed(EW'(maxc_r)) : $signed(EW'(maxf_r));
  assign step    = (err > lim) ? lim : ((err < -lim) ? -lim : err);
  assign turn    = (err == '0) || (prev_ok && (prev_neg != err[EW-1]));
  assign csum    = $signed(EW'(crs)) + step;
  assign fsum    = $signed(EW'(fin)) + step;
  assign crs_nx  = csum[EW-1] ? '0 : ((csum > $signed(EW'({CW{1'b1}}))) ? '1 : csum[CW-1:0]);
  assign fin_nx  = fsum[EW-1] ? '0 : ((fsum > $signed(EW'({FW{1'b1}}))) ? '1 : fsum[FW-1:0]);
  assign ph_sum  = {1'b0, phase} + {1'b0, frac_r};

  assign coarse        = crs;
  assign fine          = (dbit && (fin != '1)) ? fin + FW'(1) : fin;
  assign coarse_lock   = lock_c;
  assign fine_lock     = lock_f;
  assign accurate_lock = lock_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      div_r <= '0; mul_r <= '0; frac_r <= '0; maxc_r <= C_HALF; maxf_r <= F_HALF;
      dith_r <= 1'b0; accn_r <= '0;
      crs <= '0; fin <= '0; rcnt <= '0; dcnt <= '0; phase <= '0; dbit <= 1'b0;
      prev_ok <= 1'b0; prev_neg <= 1'b0; zrun <= '0;
      lock_c <= 1'b0; lock_f <= 1'b0; lock_a <= 1'b0;
    end else if (!en) begin
      st <= S_IDLE;
      dbit <= 1'b0;
      lock_c <= 1'b0; lock_f <= 1'b0; lock_a <= 1'b0;
    end else if (st == S_IDLE) begin
      st     <= closed_loop ? S_COARSE : S_OPEN;
      div_r  <= ref_div;
      mul_r  <= mul_int;
      frac_r <= mul_frac;
      maxc_r <= (max_coarse == '0) ? C_HALF : max_coarse;
      maxf_r <= (max_fine == '0) ? F_HALF : max_fine;
      dith_r <= dither_en;
      accn_r <= acc_windows;
      crs <= init_coarse; fin <= init_fine;
      rcnt <= '0; dcnt <= '0; phase <= '0; dbit <= 1'b0;
      prev_ok <= 1'b0; zrun <= '0;
    end else if (looping) begin
      if (win_end) begin
        rcnt <= '0;
        dcnt <= '0;
        case (st)
          S_COARSE: begin
            if (turn) begin
              lock_c <= 1'b1; st <= S_FINE; prev_ok <= 1'b0;
            end else begin
              crs <= crs_nx; prev_ok <= 1'b1; prev_neg <= err[EW-1];
            end
          end
          S_FINE: begin
            if (turn) begin
              lock_f <= 1'b1; st <= S_TRACK; prev_ok <= 1'b0;
            end else begin
              fin <= fin_nx; prev_ok <= 1'b1; prev_neg <= err[EW-1];
            end
          end
          default: begin
            if (dith_r) begin
              {dbit, phase} <= ph_sum;
              if (err == '0) begin
                if (zrun != '1) zrun <= zrun + AW'(1);
                if ({1'b0, zrun} + (AW+1)'(1) >= {1'b0, acc_eff}) lock_a <= 1'b1;
              end else begin
                zrun <= '0;
              end
            end
          end
        endcase
      end else begin
        rcnt <= rcnt + DW'(ref_tick);
        dcnt <= dcnt + CNTW'(dco_tick);
      end
    end
  end

  assert_fine_after_coarse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fine_lock |-> coarse_lock);

  assert_acc_needs_dither_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accurate_lock |-> (fine_lock && dith_r));

  assert_open_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OPEN && $past(st) == S_OPEN) |-> ($stable(crs) && $stable(fin)));

  assert_coarse_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_COARSE) |->
      (((crs >= $past(crs)) ? (crs - $past(crs)) : ($past(crs) - crs)) <= $past(maxc_r)));

  assert_coarse_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_c) && lock_c) |-> $stable(crs));

  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!coarse_lock && !fine_lock && !accurate_lock));
endmodule

// File: tb/sim_freq_lock_ctrl.sv
`timescale 1ns/1ps
module sim_freq_lock_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, closed_loop = 1'b0;
  logic ref_tick = 1'b0, dco_tick = 1'b0;
  logic [7:0]  ref_div = 8'd4;
  logic [11:0] mul_int = 12'd50;
  logic [15:0] mul_frac = 16'h0000;
  logic [5:0]  init_coarse = '0, max_coarse = '0;
  logic [7:0]  init_fine = '0, max_fine = '0;
  logic        dither_en = 1'b0;
  logic [3:0]  acc_windows = 4'd0;
  logic [5:0]  coarse;
  logic [7:0]  fine;
  logic        coarse_lock, fine_lock, accurate_lock;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  freq_lock_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .closed_loop(closed_loop),
    .ref_tick(ref_tick), .dco_tick(dco_tick), .ref_div(ref_div),
    .mul_int(mul_int), .mul_frac(mul_frac), .init_coarse(init_coarse),
    .init_fine(init_fine), .max_coarse(max_coarse), .max_fine(max_fine),
    .dither_en(dither_en), .acc_windows(acc_windows), .coarse(coarse),
    .fine(fine), .coarse_lock(coarse_lock), .fine_lock(fine_lock),
    .accurate_lock(accurate_lock)
  );

  // dco count, merge last dco into closing ref tick, coarse, fine, locks {c,f,a}
  localparam int VEC [11][5] = '{
    '{45, 0, 44, 100, 0}, '{48, 0, 46, 100, 0}, '{52, 0, 46, 100, 4},
    '{46, 0, 46, 103, 4}, '{49, 1, 46, 104, 4}, '{51, 0, 46, 104, 6},
    '{50, 0, 46, 104, 6}, '{50, 0, 46, 104, 7}, '{49, 0, 46, 104, 7},
    '{50, 0, 46, 105, 7}, '{51, 0, 46, 104, 7}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(bit r, bit d);
    ref_tick = r; dco_tick = d;
    @(negedge clk);
    ref_tick = 1'b0; dco_tick = 1'b0;
  endtask

  task automatic win(int n, bit m);
    int k;
    k = m ? n - 1 : n;
    for (int i = 0; i < k; i++) pulse(1'b0, 1'b1);
    for (int j = 0; j < int'(ref_div); j++) pulse(1'b1, m && (j == int'(ref_div) - 1));
  endtask

  task automatic locks_chk(string req, int exp);
    check(req, {29'd0, coarse_lock, fine_lock, accurate_lock}, exp);
  endtask

  task automatic restart();
    en = 1'b0; @(negedge clk);
    en = 1'b1; @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 coarse after reset", coarse, 0);
    check("R1 fine after reset", fine, 0);
    locks_chk("R1 locks after reset", 0);
    rst_n = 1'b1;
    @(negedge clk);

    // open loop
    closed_loop = 1'b0; init_coarse = 6'd20; init_fine = 8'd7;
    en = 1'b1; @(negedge clk);
    check("R2 open coarse load", coarse, 20);
    check("R2 open fine load", fine, 7);
    win(3, 1'b0); win(9, 1'b1);
    check("R2 open coarse held", coarse, 20);
    check("R2 open fine held", fine, 7);
    locks_chk("R2 open no lock", 0);
    init_coarse = 6'd9; @(negedge clk);
    check("R11 config change ignored while enabled", coarse, 20);
    restart();
    check("R11 config taken on re-enable", coarse, 9);

    // vector walk: two-stage lock with dithering
    en = 1'b0; @(negedge clk);
    closed_loop = 1'b1; mul_int = 12'd50; mul_frac = 16'h4000;
    init_coarse = 6'd40; init_fine = 8'd100; max_coarse = 6'd4; max_fine = 8'd3;
    dither_en = 1'b1; acc_windows = 4'd2;
    en = 1'b1; @(negedge clk);
    for (int v = 0; v < 11; v++) begin
      win(VEC[v][0], VEC[v][1] != 0);
      check($sformatf("R3/R4/R6 vec%0d coarse", v), coarse, VEC[v][2]);
      check($sformatf("R3/R7/R8 vec%0d fine", v), fine, VEC[v][3]);
      locks_chk($sformatf("R6/R7/R9 vec%0d locks", v), VEC[v][4]);
    end
    en = 1'b0; @(negedge clk);
    locks_chk("R11 locks cleared on disable", 0);

    // default step and saturation
    init_coarse = 6'd10; max_coarse = 6'd0; dither_en = 1'b0;
    en = 1'b1; @(negedge clk);
    win(0, 1'b0);
    check("R4 default half-scale coarse step", coarse, 42);
    win(0, 1'b0);
    check("R5 coarse saturates high", coarse, 63);
    win(50, 1'b0);
    check("R6 zero error freezes coarse", coarse, 63);
    locks_chk("R6 zero error coarse lock", 4);
    init_coarse = 6'd1; max_coarse = 6'd4;
    restart();
    win(100, 1'b0);
    check("R5 coarse saturates low", coarse, 0);
    locks_chk("R6 first window no reversal", 0);

    // no dithering
    init_coarse = 6'd46; init_fine = 8'd104; max_fine = 8'd0;
    mul_frac = 16'h8000; acc_windows = 4'd1; dither_en = 1'b0;
    restart();
    win(50, 1'b0); win(50, 1'b0);
    locks_chk("R7 zero error fine lock", 6);
    for (int w = 0; w < 3; w++) begin
      win(50, 1'b0);
      check("R10 no dither increment", fine, 104);
      locks_chk("R10 no accurate lock", 6);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule